// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Qualifier

This block is a bank of hardware debug comparators that sits beside a processor core. Breakpoint slots watch the fetch address. Watchpoint slots watch data accesses. Each slot has a control word and a value word, and both are loaded through a plain write port. On every presented fetch or access, each slot first checks for a raw address hit. The block then qualifies that hit against the current security state and privilege level. It can also require a second breakpoint slot, programmed as a context-identifier comparator, to match the running context.

One cycle after an access is presented, the block reports a fetch-hit flag and a data-hit flag. Each flag comes with the index of the lowest-numbered slot that fired. Turning these into exceptions is left to the surrounding logic.

Top module: `dbg_cmp_bank`

## Requirements
- R1: Control bit 0 enables a slot; a slot with bit 0 clear never fires.
- R2: A breakpoint slot acts as an address comparator only when control bits [23:21] are 0. It fires when value bits [47:2] equal the fetch word address. Fetch address bits [1:0] play no part.
- R3: A watchpoint slot fires when value bits [47:2] equal access address bits [47:2] and at least one touched byte lane is selected by control bits [8:5] (bit 5 selects lane 0). Control bit 3 permits loads and control bit 4 permits stores. A byte access touches one lane, a halfword touches lanes {1,0} or {3,2}, and a word or doubleword touches all four lanes. The size codes are 0 byte, 1 halfword, 2 word and 3 doubleword.
- R4: Control bit 1 permits hits at level 1, control bit 2 permits hits at level 0, and control bit 13 permits hits at levels 2 and 3.
- R5: Control bits [15:14] select the security filter. A value of 0 matches in either state, 2 matches only in the secure state, and 1 or 3 match only in the non-secure state. The filter uses the processor security input.
- R6: When control bit 20 (the link flag) is set, a slot also needs the breakpoint slot named in control bits [19:16] to pass. That slot passes only when it is enabled, its bits [23:20] equal 3, the current level is 0 or 1, and its value bits [31:0] equal the context identifier.
- R7: A link that names a slot outside the context-aware range (NUM_BP-NUM_CTX to NUM_BP-1, slots 4 and 5 by default) never passes, even when that slot is unimplemented. A link to a slot whose type is anything other than 3 never passes either.
- R8: An access flagged as unprivileged is checked by watchpoints as if made at level 0, whatever the current level.
- R9: Nothing fires while the global debug enable input is 0 or while debug exceptions are not allowed.
- R10: In legacy big-endian word-invariant mode, watchpoints XOR the low address bits with 3 for byte accesses and with 2 for halfword accesses before lane selection.
- R11: When several slots fire, the lowest index is reported. Hit flags and indices are registered and appear on the cycle after the access is presented. A fetch or access that is not marked valid produces no hit.
- R12: After reset every slot is disabled and both hit flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | 0 breakpoint control, 1 breakpoint value, 2 watchpoint control, 3 watchpoint value |
| wr_idx_i | input | 4 | Slot index for the write; out-of-range indices are dropped |
| wr_data_i | input | 48 | Write data (control uses bits [23:0]) |
| fetch_vld_i | input | 1 | Fetch address is valid this cycle |
| pc_i | input | 46 | Fetch word address (address bits [47:2]) |
| acc_vld_i | input | 1 | Data access is valid this cycle |
| acc_addr_i | input | 48 | Data access byte address |
| acc_size_i | input | 2 | Access size code |
| acc_wr_i | input | 1 | Access is a store |
| acc_unpriv_i | input | 1 | Access comes from an unprivileged load/store |
| secure_i | input | 1 | Processor is in the secure state |
| el_i | input | 2 | Current privilege level |
| ctx_id_i | input | 32 | Current context identifier |
| dbg_en_i | input | 1 | Global debug enable |
| excp_ok_i | input | 1 | Debug exceptions are allowed |
| be32_i | input | 1 | Legacy big-endian word-invariant mode |
| bp_hit_o | output | 1 | A breakpoint fired |
| bp_idx_o | output | 3 | Lowest firing breakpoint slot |
| wp_hit_o | output | 1 | A watchpoint fired |
| wp_idx_o | output | 2 | Lowest firing watchpoint slot |

## Verification
The fetch patterns cover several cases. Some land inside a matched word but off its first byte, or one word past it. Others land on a slot that holds a context identifier rather than an address. These separate the word-address compare from the type gate. Further fetches sweep the privilege levels and security states over single slots, and over linked pairs whose context identifier, level or target slot changes one at a time. Together they show which qualifier blocks a hit. Data accesses mix load and store, privileged and unprivileged, byte and halfword sizes at every lane offset, with the big-endian mode on and off. These tell the lane mask, the swizzle and the level override apart. Cases where two slots fire at once expose the priority order.

// File: rtl/dbg_cmp_pkg.sv
package dbg_cmp_pkg;

  localparam int CTRL_W = 24;
  localparam int LBN_W  = 4;
  localparam logic [3:0] TYPE_CTX = 4'd3;

  typedef enum logic [1:0] {
    WR_BP_CTRL = 2'd0,
    WR_BP_VAL  = 2'd1,
    WR_WP_CTRL = 2'd2,
    WR_WP_VAL  = 2'd3
  } wr_kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic [3:0]       typ;   // [23:20], bit 20 doubles as link flag
    logic [LBN_W-1:0] lbn;   // [19:16]
    logic [1:0]       ssc;   // [15:14]
    logic             hmc;   // [13]
    logic [1:0]       pac;   // [2:1]
    logic             en;    // [0]
  } bp_ctrl_t;

  typedef struct packed {
    logic             link;  // [20]
    logic [LBN_W-1:0] lbn;   // [19:16]
    logic [1:0]       ssc;   // [15:14]
    logic             hmc;   // [13]
    logic [3:0]       bas;   // [8:5]
    logic [1:0]       lsc;   // [4:3]
    logic [1:0]       pac;   // [2:1]
    logic             en;    // [0]
  } wp_ctrl_t;

  function automatic bp_ctrl_t to_bp_ctrl(input logic [CTRL_W-1:0] w);
    bp_ctrl_t c;
    c.typ = w[23:20];
    c.lbn = w[19:16];
    c.ssc = w[15:14];
    c.hmc = w[13];
    c.pac = w[2:1];
    c.en  = w[0];
    return c;
  endfunction

  function automatic wp_ctrl_t to_wp_ctrl(input logic [CTRL_W-1:0] w);
    wp_ctrl_t c;
    c.link = w[20];
    c.lbn  = w[19:16];
    c.ssc  = w[15:14];
    c.hmc  = w[13];
    c.bas  = w[8:5];
    c.lsc  = w[4:3];
    c.pac  = w[2:1];
    c.en   = w[0];
    return c;
  endfunction

  function automatic logic sec_pass(input logic [1:0] ssc, input logic secure);
    case (ssc)
      2'd0:    return 1'b1;
      2'd2:    return secure;
      default: return !secure;
    endcase
  endfunction

  function automatic logic lvl_pass(input logic [1:0] pac, input logic hmc,
                                    input logic [1:0] el);
    case (el)
      2'd0:    return pac[1];
      2'd1:    return pac[0];
      default: return hmc;
    endcase
  endfunction

endpackage

// File: rtl/dbg_ctx_match.sv
module dbg_ctx_match
  import dbg_cmp_pkg::*;
#(
  parameter int NUM_CTX = 2,
  parameter int CTX_W   = 32
) (
  input  logic [NUM_CTX-1:0]            en_i,
  input  logic [NUM_CTX-1:0][3:0]       typ_i,
  input  logic [NUM_CTX-1:0][CTX_W-1:0] val_i,
  input  logic [CTX_W-1:0]              ctx_id_i,
  input  logic [1:0]                    el_i,
  output logic [NUM_CTX-1:0]            ok_o
);

  logic low_el;
  assign low_el = (el_i < 2'd2);

  for (genvar j = 0; j < NUM_CTX; j++) begin : g_ctx
    assign ok_o[j] = en_i[j] && (typ_i[j] == TYPE_CTX) && low_el &&
                     (val_i[j] == ctx_id_i);
  end

  // context comparators stay silent at levels 2 and 3
  always_comb begin
    if (!$isunknown(ok_o) && !$isunknown(el_i) && (|ok_o)) begin
      p_ctx_low_level_r6: assert (el_i <= 2'd1);
    end
  end

endmodule

// File: rtl/dbg_slot_qual.sv
module dbg_slot_qual
  import dbg_cmp_pkg::*;
#(
  parameter int NUM_BP  = 6,
  parameter int NUM_CTX = 2
) (
  input  logic               en_i,
  input  logic               raw_i,
  input  logic [1:0]         pac_i,
  input  logic               hmc_i,
  input  logic [1:0]         ssc_i,
  input  logic               link_i,
  input  logic [LBN_W-1:0]   lbn_i,
  input  logic               secure_i,
  input  logic [1:0]         el_i,
  input  logic [NUM_CTX-1:0] ctx_ok_i,
  output logic               fire_o
);

  localparam int CTX_BASE = NUM_BP - NUM_CTX;

  logic link_ok;

  // only the top NUM_CTX breakpoint slots can be link targets
  always_comb begin
    link_ok = 1'b0;
    for (int k = 0; k < NUM_CTX; k++) begin
      if (lbn_i == LBN_W'(CTX_BASE + k)) link_ok = ctx_ok_i[k];
    end
  end

  assign fire_o = en_i && raw_i && sec_pass(ssc_i, secure_i) &&
                  lvl_pass(pac_i, hmc_i, el_i) && (!link_i || link_ok);

endmodule

// File: rtl/dbg_lowest.sv
module dbg_lowest #(
  parameter int N     = 6,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  always_comb begin
    if (!$isunknown(req_i) && any_o) begin
      p_lowest_pick_r11: assert (req_i[idx_o] &&
        ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
    end
  end

endmodule

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank
  import dbg_cmp_pkg::*;
#(
  parameter int NUM_BP   = 6,
  parameter int NUM_WP   = 4,
  parameter int NUM_CTX  = 2,
  parameter int ADDR_W   = 48,
  parameter int CTX_W    = 32,
  parameter int WR_IDX_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [1:0]               wr_kind_i,
  input  logic [WR_IDX_W-1:0]      wr_idx_i,
  input  logic [ADDR_W-1:0]        wr_data_i,
  input  logic                     fetch_vld_i,
  input  logic [ADDR_W-1:2]        pc_i,
  input  logic                     acc_vld_i,
  input  logic [ADDR_W-1:0]        acc_addr_i,
  input  logic [1:0]               acc_size_i,
  input  logic                     acc_wr_i,
  input  logic                     acc_unpriv_i,
  input  logic                     secure_i,
  input  logic [1:0]               el_i,
  input  logic [CTX_W-1:0]         ctx_id_i,
  input  logic                     dbg_en_i,
  input  logic                     excp_ok_i,
  input  logic                     be32_i,
  output logic                     bp_hit_o,
  output logic [((NUM_BP > 1) ? $clog2(NUM_BP) : 1)-1:0] bp_idx_o,
  output logic                     wp_hit_o,
  output logic [((NUM_WP > 1) ? $clog2(NUM_WP) : 1)-1:0] wp_idx_o
);

  localparam int BP_IDX_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1;
  localparam int WP_IDX_W = (NUM_WP > 1) ? $clog2(NUM_WP) : 1;
  localparam int CTX_BASE = NUM_BP - NUM_CTX;

  wr_kind_e  wr_kind;
  acc_size_e acc_size;
  assign wr_kind  = wr_kind_e'(wr_kind_i);
  assign acc_size = acc_size_e'(acc_size_i);

  // ---------------- slot registers ----------------
  bp_ctrl_t                bp_ctrl_q [NUM_BP];
  logic [ADDR_W-1:0]       bp_val_q  [NUM_BP];
  wp_ctrl_t                wp_ctrl_q [NUM_WP];
  logic [ADDR_W-1:2]       wp_val_q  [NUM_WP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BP; i++) begin
        bp_ctrl_q[i] <= '0;
        bp_val_q[i]  <= '0;
      end
      for (int i = 0; i < NUM_WP; i++) begin
        wp_ctrl_q[i] <= '0;
        wp_val_q[i]  <= '0;
      end
    end else if (wr_en_i) begin
      for (int i = 0; i < NUM_BP; i++) begin
        if (wr_idx_i == WR_IDX_W'(i)) begin
          if (wr_kind == WR_BP_CTRL) bp_ctrl_q[i] <= to_bp_ctrl(wr_data_i[CTRL_W-1:0]);
          if (wr_kind == WR_BP_VAL)  bp_val_q[i]  <= wr_data_i;
        end
      end
      for (int i = 0; i < NUM_WP; i++) begin
        if (wr_idx_i == WR_IDX_W'(i)) begin
          if (wr_kind == WR_WP_CTRL) wp_ctrl_q[i] <= to_wp_ctrl(wr_data_i[CTRL_W-1:0]);
          if (wr_kind == WR_WP_VAL)  wp_val_q[i]  <= wr_data_i[ADDR_W-1:2];
        end
      end
    end
  end

  // ---------------- shared qualifiers ----------------
  logic       gate;
  logic [1:0] wp_el;
  logic [1:0] lane_lo;
  logic [3:0] lane_mask;

  assign gate  = dbg_en_i && excp_ok_i;
  assign wp_el = acc_unpriv_i ? 2'd0 : el_i;

  // undo legacy big-endian sub-word address swizzle
  always_comb begin
    lane_lo = acc_addr_i[1:0];
    if (be32_i) begin
      if (acc_size == SZ_BYTE)      lane_lo = lane_lo ^ 2'd3;
      else if (acc_size == SZ_HALF) lane_lo = lane_lo ^ 2'd2;
    end
    case (acc_size)
      SZ_BYTE: lane_mask = 4'b0001 << lane_lo;
      SZ_HALF: lane_mask = lane_lo[1] ? 4'b1100 : 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  end

  // ---------------- context comparators ----------------
  logic [NUM_CTX-1:0]            ctx_en;
  logic [NUM_CTX-1:0][3:0]       ctx_typ;
  logic [NUM_CTX-1:0][CTX_W-1:0] ctx_val;
  logic [NUM_CTX-1:0]            ctx_ok;

  for (genvar j = 0; j < NUM_CTX; j++) begin : g_ctx_src
    assign ctx_en[j]  = bp_ctrl_q[CTX_BASE + j].en;
    assign ctx_typ[j] = bp_ctrl_q[CTX_BASE + j].typ;
    assign ctx_val[j] = bp_val_q[CTX_BASE + j][CTX_W-1:0];
  end

  dbg_ctx_match #(
    .NUM_CTX (NUM_CTX),
    .CTX_W   (CTX_W)
  ) u_ctx (
    .en_i     (ctx_en),
    .typ_i    (ctx_typ),
    .val_i    (ctx_val),
    .ctx_id_i (ctx_id_i),
    .el_i     (el_i),
    .ok_o     (ctx_ok)
  );

  // ---------------- breakpoint slots ----------------
  logic [NUM_BP-1:0] bp_fire;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    logic raw;
    assign raw = fetch_vld_i && (bp_ctrl_q[i].typ[3:1] == 3'd0) &&
                 (bp_val_q[i][ADDR_W-1:2] == pc_i);

    dbg_slot_qual #(
      .NUM_BP  (NUM_BP),
      .NUM_CTX (NUM_CTX)
    ) u_qual (
      .en_i     (bp_ctrl_q[i].en),
      .raw_i    (raw),
      .pac_i    (bp_ctrl_q[i].pac),
      .hmc_i    (bp_ctrl_q[i].hmc),
      .ssc_i    (bp_ctrl_q[i].ssc),
      .link_i   (bp_ctrl_q[i].typ[0]),
      .lbn_i    (bp_ctrl_q[i].lbn),
      .secure_i (secure_i),
      .el_i     (el_i),
      .ctx_ok_i (ctx_ok),
      .fire_o   (bp_fire[i])
    );
  end

  // ---------------- watchpoint slots ----------------
  logic [NUM_WP-1:0] wp_fire;

  for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
    logic raw;
    assign raw = acc_vld_i && (wp_val_q[i] == acc_addr_i[ADDR_W-1:2]) &&
                 (|(lane_mask & wp_ctrl_q[i].bas)) &&
                 (acc_wr_i ? wp_ctrl_q[i].lsc[1] : wp_ctrl_q[i].lsc[0]);

    dbg_slot_qual #(
      .NUM_BP  (NUM_BP),
      .NUM_CTX (NUM_CTX)
    ) u_qual (
      .en_i     (wp_ctrl_q[i].en),
      .raw_i    (raw),
      .pac_i    (wp_ctrl_q[i].pac),
      .hmc_i    (wp_ctrl_q[i].hmc),
      .ssc_i    (wp_ctrl_q[i].ssc),
      .link_i   (wp_ctrl_q[i].link),
      .lbn_i    (wp_ctrl_q[i].lbn),
      .secure_i (secure_i),
      .el_i     (wp_el),
      .ctx_ok_i (ctx_ok),
      .fire_o   (wp_fire[i])
    );
  end

  // ---------------- priority and output stage ----------------
  logic                bp_any, wp_any;
  logic [BP_IDX_W-1:0] bp_sel;
  logic [WP_IDX_W-1:0] wp_sel;

  dbg_lowest #(.N(NUM_BP), .IDX_W(BP_IDX_W)) u_bp_pick (
    .req_i (bp_fire),
    .any_o (bp_any),
    .idx_o (bp_sel)
  );

  dbg_lowest #(.N(NUM_WP), .IDX_W(WP_IDX_W)) u_wp_pick (
    .req_i (wp_fire),
    .any_o (wp_any),
    .idx_o (wp_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_hit_o <= 1'b0;
      bp_idx_o <= '0;
      wp_hit_o <= 1'b0;
      wp_idx_o <= '0;
    end else begin
      bp_hit_o <= gate && bp_any;
      bp_idx_o <= bp_sel;
      wp_hit_o <= gate && wp_any;
      wp_idx_o <= wp_sel;
    end
  end

  // ---------------- assertions ----------------
  p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(dbg_en_i && excp_ok_i) |-> (!bp_hit_o && !wp_hit_o));

  p_bp_needs_vld_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(fetch_vld_i) |-> !bp_hit_o);

  p_wp_needs_vld_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(acc_vld_i) |-> !wp_hit_o);

  p_bp_idx_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_hit_o |-> (int'(bp_idx_o) < NUM_BP));

  p_wp_idx_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_hit_o |-> (int'(wp_idx_o) < NUM_WP));

endmodule

// File: tb/dbg_cmp_bank_bench.sv
module dbg_cmp_bank_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_kind = '0;
  logic [3:0]  wr_idx = '0;
  logic [47:0] wr_data = '0;
  logic        fetch_vld = 1'b0;
  logic [47:2] pc = '0;
  logic        acc_vld = 1'b0;
  logic [47:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic        acc_wr = 1'b0;
  logic        acc_unpriv = 1'b0;
  logic        secure = 1'b0;
  logic [1:0]  el = 2'd1;
  logic [31:0] ctx_id = '0;
  logic        dbg_en = 1'b1;
  logic        excp_ok = 1'b1;
  logic        be32 = 1'b0;
  logic        bp_hit, wp_hit;
  logic [2:0]  bp_idx;
  logic [1:0]  wp_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [6:0] q_exp [$];
  string      q_tag [$];

  always #2.5 clk = ~clk;

  dbg_cmp_bank u_dbg_cmp_bank (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_kind_i(wr_kind), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .fetch_vld_i(fetch_vld), .pc_i(pc),
    .acc_vld_i(acc_vld), .acc_addr_i(acc_addr), .acc_size_i(acc_size),
    .acc_wr_i(acc_wr), .acc_unpriv_i(acc_unpriv),
    .secure_i(secure), .el_i(el), .ctx_id_i(ctx_id),
    .dbg_en_i(dbg_en), .excp_ok_i(excp_ok), .be32_i(be32),
    .bp_hit_o(bp_hit), .bp_idx_o(bp_idx), .wp_hit_o(wp_hit), .wp_idx_o(wp_idx)
  );

  function automatic logic [47:0] ctl(bit en, bit [1:0] pac, bit hmc, bit [1:0] ssc,
                                      bit [3:0] lbn, bit [3:0] typ, bit [3:0] bas,
                                      bit [1:0] lsc);
    logic [47:0] w;
    w = '0;
    w[0] = en; w[2:1] = pac; w[4:3] = lsc; w[8:5] = bas;
    w[13] = hmc; w[15:14] = ssc; w[19:16] = lbn; w[23:20] = typ;
    return w;
  endfunction

  // monitor: compares registered outputs one edge after each presented access
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        logic [6:0] e, g;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        g = {bp_hit, bp_hit ? bp_idx : 3'd0, wp_hit, wp_hit ? wp_idx : 2'd0};
        checks++;
        if (g !== e) begin
          errors++;
          $display("FAIL %s: got bp=%0b/%0d wp=%0b/%0d expected bp=%0b/%0d wp=%0b/%0d",
                   t, g[6], g[5:3], g[2], g[1:0], e[6], e[5:3], e[2], e[1:0]);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] k, input int idx, input logic [47:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = k; wr_idx = 4'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input logic fv, input logic [47:0] p, input logic av,
                      input logic [47:0] a, input logic [1:0] sz, input logic w,
                      input logic up, input logic ebh, input logic [2:0] ebi,
                      input logic ewh, input logic [1:0] ewi, input string tag);
    @(negedge clk);
    fetch_vld = fv; pc = p[47:2];
    acc_vld = av; acc_addr = a; acc_size = sz; acc_wr = w; acc_unpriv = up;
    q_exp.push_back({ebh, ebh ? ebi : 3'd0, ewh, ewh ? ewi : 2'd0});
    q_tag.push_back(tag);
    @(negedge clk);
    fetch_vld = 1'b0; acc_vld = 1'b0; acc_unpriv = 1'b0;
  endtask

  task automatic fetch(input logic [47:0] p, input logic eh, input logic [2:0] ei,
                       input string tag);
    step(1'b1, p, 1'b0, '0, 2'd0, 1'b0, 1'b0, eh, ei, 1'b0, 2'd0, tag);
  endtask

  task automatic access(input logic [47:0] a, input logic [1:0] sz, input logic w,
                        input logic up, input logic eh, input logic [1:0] ei,
                        input string tag);
    step(1'b0, '0, 1'b1, a, sz, w, up, 1'b0, 3'd0, eh, ei, tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (bp_hit !== 1'b0 || wp_hit !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset: got bp=%0b wp=%0b expected 0 0", bp_hit, wp_hit);
    end
    rst_ni = 1'b1;

    // R12: all slots disabled after reset, even with zero addresses
    fetch(48'h0, 0, 0, "R12 bp disabled after reset");
    access(48'h0, 2'd2, 1'b1, 1'b0, 0, 0, "R12 wp disabled after reset");

    // R2 / R11
    wr(2'd0, 1, ctl(1, 3, 1, 0, 0, 0, 0, 0)); wr(2'd1, 1, 48'h1000);
    wr(2'd0, 3, ctl(1, 3, 1, 0, 0, 0, 0, 0)); wr(2'd1, 3, 48'h1000);
    fetch(48'h1000, 1, 1, "R11 lowest of two");
    fetch(48'h1003, 1, 1, "R2 low pc bits ignored");
    fetch(48'h1004, 0, 0, "R2 next word misses");
    step(1'b0, 48'h1000, 1'b0, '0, 2'd0, 1'b0, 1'b0, 0, 0, 0, 0, "R11 no valid no hit");

    // R1
    wr(2'd0, 1, ctl(0, 3, 1, 0, 0, 0, 0, 0));
    fetch(48'h1000, 1, 3, "R1 disabled slot skipped");

    // R4
    wr(2'd0, 3, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    el = 2'd0; fetch(48'h1000, 0, 0, "R4 level0 blocked");
    el = 2'd1; fetch(48'h1000, 1, 3, "R4 level1 allowed");
    el = 2'd2; fetch(48'h1000, 0, 0, "R4 level2 blocked");
    wr(2'd0, 3, ctl(1, 1, 1, 0, 0, 0, 0, 0));
    el = 2'd3; fetch(48'h1000, 1, 3, "R4 level3 via bit13");
    el = 2'd1;

    // R5
    wr(2'd0, 3, ctl(1, 3, 1, 2, 0, 0, 0, 0));
    secure = 0; fetch(48'h1000, 0, 0, "R5 ssc2 nonsecure blocked");
    secure = 1; fetch(48'h1000, 1, 3, "R5 ssc2 secure hit");
    wr(2'd0, 3, ctl(1, 3, 1, 1, 0, 0, 0, 0));
    fetch(48'h1000, 0, 0, "R5 ssc1 secure blocked");
    wr(2'd0, 3, ctl(1, 3, 1, 3, 0, 0, 0, 0));
    secure = 0; fetch(48'h1000, 1, 3, "R5 ssc3 nonsecure hit");
    wr(2'd0, 3, ctl(1, 3, 1, 0, 0, 0, 0, 0));

    // R9
    dbg_en = 0; fetch(48'h1000, 0, 0, "R9 global enable off");
    dbg_en = 1; excp_ok = 0; fetch(48'h1000, 0, 0, "R9 exceptions not allowed");
    excp_ok = 1;

    // R6 linked context
    wr(2'd0, 5, ctl(1, 0, 0, 0, 0, 3, 0, 0)); wr(2'd1, 5, 48'hCAFE0001);
    wr(2'd0, 2, ctl(1, 3, 1, 0, 5, 1, 0, 0)); wr(2'd1, 2, 48'h2000);
    ctx_id = 32'hCAFE0001;
    fetch(48'h2000, 1, 2, "R6 link context matches");
    ctx_id = 32'hCAFE0002; fetch(48'h2000, 0, 0, "R6 context mismatch");
    ctx_id = 32'hCAFE0001;
    el = 2'd2; fetch(48'h2000, 0, 0, "R6 context blocked at level2");
    el = 2'd1;
    fetch(48'hCAFE0000, 0, 0, "R2 context slot not an address comparator");
    wr(2'd0, 5, ctl(0, 0, 0, 0, 0, 3, 0, 0));
    fetch(48'h2000, 0, 0, "R6 disabled link target");
    wr(2'd0, 5, ctl(1, 0, 0, 0, 0, 3, 0, 0));

    // R7
    wr(2'd0, 3, ctl(1, 0, 0, 0, 0, 3, 0, 0)); wr(2'd1, 3, 48'hCAFE0001);
    wr(2'd0, 2, ctl(1, 3, 1, 0, 3, 1, 0, 0));
    fetch(48'h2000, 0, 0, "R7 link below context range");
    wr(2'd0, 2, ctl(1, 3, 1, 0, 7, 1, 0, 0));
    fetch(48'h2000, 0, 0, "R7 link to unimplemented slot");
    wr(2'd0, 4, ctl(1, 0, 0, 0, 0, 5, 0, 0)); wr(2'd1, 4, 48'hCAFE0001);
    wr(2'd0, 2, ctl(1, 3, 1, 0, 4, 1, 0, 0));
    fetch(48'h2000, 0, 0, "R7 link target type 5");
    wr(2'd0, 4, ctl(1, 0, 0, 0, 0, 3, 0, 0));
    fetch(48'h2000, 1, 2, "R7 slot 4 in context range");

    // R3 / R8 watchpoints
    wr(2'd2, 0, ctl(1, 3, 1, 0, 0, 0, 4'hF, 2'b10)); wr(2'd3, 0, 48'h4000);
    wr(2'd2, 2, ctl(1, 1, 0, 0, 0, 0, 4'hF, 2'b11)); wr(2'd3, 2, 48'h4000);
    access(48'h4000, 2'd2, 1, 0, 1, 0, "R3 store hits lowest wp");
    access(48'h4004, 2'd2, 0, 0, 0, 0, "R3 other word misses");
    access(48'h4000, 2'd2, 0, 0, 1, 2, "R3 load skips store-only slot");
    access(48'h4000, 2'd2, 0, 1, 0, 0, "R8 unpriv load seen as level0");
    wr(2'd2, 0, ctl(1, 2, 0, 0, 0, 0, 4'hF, 2'b10));
    access(48'h4000, 2'd2, 1, 0, 1, 2, "R8 priv store skips level0-only slot");
    access(48'h4000, 2'd2, 1, 1, 1, 0, "R8 unpriv store hits level0-only slot");

    // R10 / R3 lanes
    wr(2'd2, 1, ctl(1, 3, 1, 0, 0, 0, 4'b0001, 2'b11)); wr(2'd3, 1, 48'h5000);
    be32 = 0; access(48'h5003, 2'd0, 0, 0, 0, 0, "R3 byte lane3 not selected");
    access(48'h5000, 2'd0, 0, 0, 1, 1, "R3 byte lane0 selected");
    be32 = 1; access(48'h5003, 2'd0, 0, 0, 1, 1, "R10 byte xor 3");
    access(48'h5002, 2'd1, 0, 0, 1, 1, "R10 half xor 2 hits");
    access(48'h5000, 2'd1, 0, 0, 0, 0, "R10 half xor 2 misses");
    be32 = 0;

    // R9 / R11 combined
    dbg_en = 0; access(48'h4000, 2'd2, 1, 1, 0, 0, "R9 wp gated");
    dbg_en = 1;
    step(1'b1, 48'h2000, 1'b1, 48'h4000, 2'd2, 1'b1, 1'b1, 1, 2, 1, 0,
         "R11 fetch and access together");

    wait (q_exp.size() == 0);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule